// File: doc/BRIEF.md
# Mode-Banked General Register File

This block holds the sixteen 32-bit general registers of a processor core together with its status word and one saved status word per exception mode. Some logical registers map to different physical storage depending on the processor mode held in the low five bits of the status word. The block presents the correct physical register for every logical index (0 to 15) at two combinational read ports and one clocked write port. The mode-dependent register sets are never copied. They are selected through an index map, so changing the mode changes which storage the ports reach on the next cycle.

Registers 13 and 14 have one private copy per exception mode. User and system mode share one copy. The fast-interrupt mode also has its own copy of registers 8 to 12. Registers 0 to 7 and 15 are common to all modes. An override input forces all three register ports onto the user/system copies, whatever the current mode. This is how a privileged routine reaches the user stack pointer and link register.

A status write that names an encoding outside the seven valid modes is refused, and the block raises an error pulse. Decode, arithmetic and memory access sit outside this block.

Top module: `mode_regfile`

## Requirements
- R1: The mode is status bit field [4:0]. The valid encodings are 0x10 user, 0x11 fast interrupt, 0x12 interrupt, 0x13 supervisor, 0x17 abort, 0x1B undefined and 0x1F system. The status word always holds a valid mode.
- R2: A synchronous active-high reset loads the status word with 0x000000D3 (supervisor mode, both interrupt masks set). It also clears every physical register and every saved status word to zero.
- R3: Registers 0 to 7 and register 15 are one shared copy, visible unchanged in every mode.
- R4: Registers 13 and 14 have one private copy each in the fast-interrupt, interrupt, supervisor, abort and undefined modes. User mode and system mode share a single copy.
- R5: Each of the five exception modes has its own saved status word, read on `sv_rdata` and written with `sv_we`. In user or system mode `sv_rdata` reads 0 and `sv_we` has no effect.
- R6: In fast-interrupt mode, registers 8 to 12 use a private copy. Every other mode uses one shared copy of these five registers.
- R7: A status write whose mode field equals the current mode updates the status word only. Every register keeps its mapping.
- R8: A status write with an invalid mode field leaves the status word unchanged. `mode_err` is then high for the one cycle after that write.
- R9: While `usr_view` is 1, reads and writes of registers 13 and 14 reach the user/system copy in every mode. In fast-interrupt mode, accesses to registers 8 to 12 also reach the shared copy.
- R10: Reads are combinational, and writes take effect at the rising clock edge. A register write or saved-status write issued in the same cycle as a mode change lands in the storage of the old mode.
- R11: The two read ports are independent and may address different registers in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_a_idx | input | 4 | Logical index for read port A |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Logical index for read port B |
| rd_b_data | output | 32 | Read port B data |
| usr_view | input | 1 | Forces all register ports onto the user/system copies |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Logical index for the write |
| wr_data | input | 32 | Register write data |
| st_we | input | 1 | Status word write enable |
| st_wdata | input | 32 | New status word |
| status | output | 32 | Current status word |
| sv_we | input | 1 | Saved-status write enable for the current mode |
| sv_wdata | input | 32 | Saved-status write data |
| sv_rdata | output | 32 | Saved status of the current mode |
| mode_err | output | 1 | Pulse after a refused status write |

## Verification
A register write, a saved-status write and a status write that changes the mode can all occur in the same cycle. This is the collision that matters here: the data must land in the storage of the outgoing mode. The bench issues all three together while moving from supervisor to interrupt mode. It then reads register 13 and the saved status in the interrupt mode, where both must still show the interrupt-mode values. It switches back to supervisor mode, where the new values must appear.

// File: rtl/mrf_pkg.sv
package mrf_pkg;

    localparam logic [4:0] MD_USR = 5'h10;
    localparam logic [4:0] MD_FIQ = 5'h11;
    localparam logic [4:0] MD_IRQ = 5'h12;
    localparam logic [4:0] MD_SVC = 5'h13;
    localparam logic [4:0] MD_ABT = 5'h17;
    localparam logic [4:0] MD_UND = 5'h1B;
    localparam logic [4:0] MD_SYS = 5'h1F;

    localparam logic [7:0] RESET_STATUS_LO = 8'hD3;

    // Storage set for registers 13/14 and saved status
    typedef enum logic [2:0] {
        BK_USR = 3'd0,
        BK_FIQ = 3'd1,
        BK_IRQ = 3'd2,
        BK_SVC = 3'd3,
        BK_ABT = 3'd4,
        BK_UND = 3'd5
    } bank_e;

    localparam int NUM_BANKS   = 6;
    localparam int NUM_SAVED   = NUM_BANKS - 1;
    localparam int NUM_LOGICAL = 16;

    // Physical slot layout
    localparam int LOW_SHARED  = 8;               // logical 0..7
    localparam int HI_COUNT    = 5;               // logical 8..12
    localparam int HI_SHARED   = LOW_SHARED;      // base of shared 8..12
    localparam int HI_FIQ      = HI_SHARED + HI_COUNT;
    localparam int PC_SLOT     = HI_FIQ + HI_COUNT;
    localparam int BANKED_BASE = PC_SLOT + 1;
    localparam int NUM_SLOTS   = BANKED_BASE + 2 * NUM_BANKS;
    localparam int SLOT_W      = $clog2(NUM_SLOTS);

    function automatic logic mode_valid(input logic [4:0] m);
        case (m)
            MD_USR, MD_FIQ, MD_IRQ, MD_SVC, MD_ABT, MD_UND, MD_SYS: mode_valid = 1'b1;
            default: mode_valid = 1'b0;
        endcase
    endfunction

    function automatic bank_e mode_bank(input logic [4:0] m);
        case (m)
            MD_FIQ:  mode_bank = BK_FIQ;
            MD_IRQ:  mode_bank = BK_IRQ;
            MD_SVC:  mode_bank = BK_SVC;
            MD_ABT:  mode_bank = BK_ABT;
            MD_UND:  mode_bank = BK_UND;
            default: mode_bank = BK_USR;
        endcase
    endfunction

endpackage

// File: rtl/mrf_bank_map.sv
module mrf_bank_map
    import mrf_pkg::*;
(
    input  logic [3:0]        idx,
    input  bank_e             bank,
    input  logic              usr_view,
    output logic [SLOT_W-1:0] slot
);

    bank_e eff_bank;

    always_comb begin
        eff_bank = usr_view ? BK_USR : bank;
        if (int'(idx) < LOW_SHARED) begin
            slot = SLOT_W'(idx);
        end else if (int'(idx) < LOW_SHARED + HI_COUNT) begin
            if (eff_bank == BK_FIQ)
                slot = SLOT_W'(HI_FIQ + int'(idx) - LOW_SHARED);
            else
                slot = SLOT_W'(HI_SHARED + int'(idx) - LOW_SHARED);
        end else if (idx == 4'd15) begin
            slot = SLOT_W'(PC_SLOT);
        end else begin
            slot = SLOT_W'(BANKED_BASE + 2 * int'(eff_bank) + int'(idx) - 13);
        end
    end

endmodule

// File: rtl/mrf_status.sv
module mrf_status
    import mrf_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          st_we,
    input  logic [DW-1:0] st_wdata,
    input  logic          sv_we,
    input  logic [DW-1:0] sv_wdata,
    output logic [DW-1:0] status_q,
    output logic [DW-1:0] sv_rdata,
    output bank_e         bank,
    output logic          mode_err
);

    localparam int SIDX_W = $clog2(NUM_SAVED);

    typedef struct packed {
        logic [DW-1:0]                status;
        logic [NUM_SAVED-1:0][DW-1:0] saved;
        logic                         err;
    } st_t;

    st_t st_d, st_q;
    logic [SIDX_W-1:0] sidx;

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        bank     = mode_bank(st_q.status[4:0]);
        sidx     = SIDX_W'(int'(bank) - 1);
        sv_rdata = '0;
        if (bank != BK_USR) begin
            sv_rdata = st_q.saved[sidx];
            if (sv_we)
                st_d.saved[sidx] = sv_wdata;
        end
        if (st_we) begin
            if (mode_valid(st_wdata[4:0]))
                st_d.status = st_wdata;
            else
                st_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= '0;
            st_q.status <= DW'(RESET_STATUS_LO);
        end else begin
            st_q <= st_d;
        end
    end

    assign status_q = st_q.status;
    assign mode_err = st_q.err;

    // R2: first cycle out of reset shows the reset status word
    a_r2_reset_status: assert property (@(posedge clk) $fell(rst) |-> status_q == DW'(RESET_STATUS_LO));

    // R1: status always carries a legal mode
    a_r1_mode_legal: assert property (@(posedge clk) disable iff (rst) mode_valid(status_q[4:0]));

    // R8: refused write keeps status and raises error next cycle
    a_r8_refused: assert property (@(posedge clk) disable iff (rst)
        (st_we && !mode_valid(st_wdata[4:0])) |=> (mode_err && $stable(status_q)));

    // R7: same-mode write keeps the storage selection
    a_r7_same_mode: assert property (@(posedge clk) disable iff (rst)
        (st_we && st_wdata[4:0] == status_q[4:0]) |=> $stable(bank));

    // R5: user/system mode has no saved status
    a_r5_no_saved: assert property (@(posedge clk) disable iff (rst)
        (bank == BK_USR) |-> sv_rdata == '0);

endmodule

// File: rtl/mode_regfile.sv
module mode_regfile
    import mrf_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [3:0]    rd_a_idx,
    output logic [DW-1:0] rd_a_data,
    input  logic [3:0]    rd_b_idx,
    output logic [DW-1:0] rd_b_data,
    input  logic          usr_view,
    input  logic          wr_en,
    input  logic [3:0]    wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic          st_we,
    input  logic [DW-1:0] st_wdata,
    output logic [DW-1:0] status,
    input  logic          sv_we,
    input  logic [DW-1:0] sv_wdata,
    output logic [DW-1:0] sv_rdata,
    output logic          mode_err
);

    localparam int NPORT = 3;   // read A, read B, write
    localparam int P_WR  = 2;

    typedef struct packed {
        logic [NUM_SLOTS-1:0][DW-1:0] regs;
    } rf_t;

    rf_t   rf_d, rf_q;
    bank_e cur_bank;

    logic [3:0]        port_idx  [NPORT];
    logic [SLOT_W-1:0] port_slot [NPORT];

    assign port_idx[0]    = rd_a_idx;
    assign port_idx[1]    = rd_b_idx;
    assign port_idx[P_WR] = wr_idx;

    mrf_status #(.DW(DW)) u_status (
        .clk      (clk),
        .rst      (rst),
        .st_we    (st_we),
        .st_wdata (st_wdata),
        .sv_we    (sv_we),
        .sv_wdata (sv_wdata),
        .status_q (status),
        .sv_rdata (sv_rdata),
        .bank     (cur_bank),
        .mode_err (mode_err)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_map
        mrf_bank_map u_map (
            .idx      (port_idx[p]),
            .bank     (cur_bank),
            .usr_view (usr_view),
            .slot     (port_slot[p])
        );
    end

    always_comb begin
        rf_d = rf_q;
        if (wr_en)
            rf_d.regs[port_slot[P_WR]] = wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst)
            rf_q <= '0;
        else
            rf_q <= rf_d;
    end

    assign rd_a_data = rf_q.regs[port_slot[0]];
    assign rd_b_data = rf_q.regs[port_slot[1]];

    // R10: a write with no mode change is readable at the same index next cycle
    a_r10_write_lands: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !st_we) |=>
            ((rd_a_idx == $past(wr_idx) && usr_view == $past(usr_view)) |-> rd_a_data == $past(wr_data)));

    // R3: register 15 reads identically on both ports regardless of mode
    a_r3_pc_shared: assert property (@(posedge clk) disable iff (rst)
        (rd_a_idx == 4'd15 && rd_b_idx == 4'd15) |-> rd_a_data == rd_b_data);

endmodule

// File: tb/mode_regfile_test.sv
`timescale 1ns/1ps
module mode_regfile_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [31:0] rd_a_data, rd_b_data, wr_data = '0;
    logic        usr_view = 1'b0, wr_en = 1'b0, st_we = 1'b0, sv_we = 1'b0;
    logic [31:0] st_wdata = '0, status, sv_wdata = '0, sv_rdata;
    logic        mode_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        int          sel;   // 0 rd_a, 1 rd_b, 2 status, 3 sv_rdata, 4 mode_err
        logic [31:0] exp;
        string       req;
    } item_t;
    item_t sb[$];

    always #4 clk = ~clk;

    mode_regfile uut (
        .clk(clk), .rst(rst),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .usr_view(usr_view),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .st_we(st_we), .st_wdata(st_wdata), .status(status),
        .sv_we(sv_we), .sv_wdata(sv_wdata), .sv_rdata(sv_rdata),
        .mode_err(mode_err)
    );

    // Monitor: compare queued expectations away from the active edge
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb.pop_front();
            case (it.sel)
                0: act = rd_a_data;
                1: act = rd_b_data;
                2: act = status;
                3: act = sv_rdata;
                default: act = {31'd0, mode_err};
            endcase
            checks++;
            if (act !== it.exp) begin
                fails++;
                $display("FAIL %s: sel %0d got %h expected %h", it.req, it.sel, act, it.exp);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
        wr_en = 1'b0; st_we = 1'b0; sv_we = 1'b0;
    endtask

    task automatic chk(input int sel, input logic [31:0] exp, input string req);
        item_t it;
        it.sel = sel; it.exp = exp; it.req = req;
        sb.push_back(it);
    endtask

    task automatic wreg(input logic [3:0] i, input logic [31:0] d, input logic uv);
        wr_en = 1'b1; wr_idx = i; wr_data = d; usr_view = uv;
        step();
        usr_view = 1'b0;
    endtask

    task automatic setst(input logic [31:0] v);
        st_we = 1'b1; st_wdata = v;
        step();
    endtask

    task automatic svw(input logic [31:0] v);
        sv_we = 1'b1; sv_wdata = v;
        step();
    endtask

    task automatic rd(input logic [3:0] i, input logic uv, input logic [31:0] exp, input string req);
        rd_a_idx = i; usr_view = uv;
        chk(0, exp, req);
        step();
        usr_view = 1'b0;
    endtask

    initial begin
        repeat (3) step();
        rst = 1'b0;
        // R2 reset state (still in reset-loaded supervisor mode)
        chk(2, 32'h0000_00D3, "R2 status");
        chk(4, 32'h0, "R8 err idle");
        chk(3, 32'h0, "R2 saved");
        rd(4'd0, 0, 32'h0, "R2 r0");
        rd(4'd13, 0, 32'h0, "R2 r13");

        // Supervisor fills
        wreg(4'd13, 32'h5300_0001, 0);
        wreg(4'd14, 32'h5300_0002, 0);
        wreg(4'd8,  32'hAAAA_0008, 0);
        wreg(4'd0,  32'h0000_C0DE, 0);
        wreg(4'd15, 32'h0000_0100, 0);
        rd(4'd13, 0, 32'h5300_0001, "R10 write then read");

        // Interrupt mode
        setst(32'h0000_00D2);
        rd(4'd13, 0, 32'h0, "R4 irq r13 private");
        rd(4'd8, 0, 32'hAAAA_0008, "R6 irq r8 shared");
        rd(4'd0, 0, 32'h0000_C0DE, "R3 r0 shared");
        rd(4'd15, 0, 32'h0000_0100, "R3 r15 shared");
        wreg(4'd13, 32'h1200_0001, 0);

        // Fast interrupt mode
        setst(32'h0000_00D1);
        rd(4'd8, 0, 32'h0, "R6 fiq r8 private");
        wreg(4'd8, 32'hF1F1_0008, 0);
        rd(4'd8, 0, 32'hF1F1_0008, "R6 fiq r8 written");
        rd(4'd12, 0, 32'h0, "R6 fiq r12 private");
        rd(4'd13, 0, 32'h0, "R4 fiq r13 private");
        rd(4'd8, 1, 32'hAAAA_0008, "R9 fiq override r8");
        rd(4'd15, 0, 32'h0000_0100, "R3 r15 in fiq");

        // User mode
        setst(32'h0000_0010);
        rd(4'd8, 0, 32'hAAAA_0008, "R6 user r8 shared");
        wreg(4'd13, 32'hDD00_0013, 0);
        svw(32'h1234_5678);
        chk(3, 32'h0, "R5 user saved ignored");

        // System mode shares user copy
        setst(32'h0000_001F);
        rd(4'd13, 0, 32'hDD00_0013, "R4 sys shares user r13");
        chk(3, 32'h0, "R5 sys saved zero");

        // Back to supervisor, override access
        setst(32'h0000_00D3);
        rd(4'd13, 0, 32'h5300_0001, "R4 svc r13 kept");
        rd(4'd14, 0, 32'h5300_0002, "R4 svc r14 kept");
        rd(4'd13, 1, 32'hDD00_0013, "R9 override read r13");
        wreg(4'd14, 32'hEE00_0014, 1);
        rd(4'd14, 0, 32'h5300_0002, "R9 own r14 untouched");
        setst(32'h0000_001F);
        rd(4'd14, 0, 32'hEE00_0014, "R9 override write landed");
        setst(32'h0000_00D3);

        // Invalid modes
        setst(32'h0000_00D5);
        chk(4, 32'h1, "R8 err after bad mode");
        chk(2, 32'h0000_00D3, "R8 status kept");
        step();
        chk(4, 32'h0, "R8 err one cycle");
        setst(32'h0000_0000);
        chk(4, 32'h1, "R8 err on zero mode");
        step();

        // Same mode write
        setst(32'hF000_00D3);
        chk(2, 32'hF000_00D3, "R7 status updated");
        rd(4'd13, 0, 32'h5300_0001, "R7 mapping kept");

        // Same-cycle register write, saved write and mode change
        wr_en = 1'b1; wr_idx = 4'd13; wr_data = 32'h5300_00F1;
        sv_we = 1'b1; sv_wdata = 32'h5AED_0013;
        st_we = 1'b1; st_wdata = 32'h0000_00D2;
        step();
        rd(4'd13, 0, 32'h1200_0001, "R10 irq r13 untouched");
        chk(3, 32'h0, "R10 irq saved untouched");
        setst(32'h0000_00D3);
        rd(4'd13, 0, 32'h5300_00F1, "R10 old bank got write");
        chk(3, 32'h5AED_0013, "R10 old saved got write");

        // Saved status per mode
        setst(32'h0000_00D2);
        svw(32'h5AED_0012);
        setst(32'h0000_00D7);
        chk(3, 32'h0, "R5 abort saved private");
        step();
        setst(32'h0000_00D2);
        chk(3, 32'h5AED_0012, "R5 irq saved kept");
        step();

        // Two ports at once
        rd_b_idx = 4'd0;
        chk(1, 32'h0000_C0DE, "R11 port b");
        rd(4'd13, 0, 32'h1200_0001, "R11 port a");

        // Reset mid-run
        rst = 1'b1;
        step();
        rst = 1'b0;
        chk(2, 32'h0000_00D3, "R2 status after reset");
        rd(4'd0, 0, 32'h0, "R2 r0 cleared");
        rd(4'd13, 0, 32'h0, "R2 r13 cleared");
        step();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule